// File: doc/BRIEF.md
# Smart-Card Character Receiver

This block takes one asynchronous serial line, as used between a card reader and a smart card, and turns each character frame into a byte plus status. A frame is a low start bit, eight data bits sent least significant bit first, one parity bit and one or two high stop bits. The bit period is a run-time input given as clocks per bit minus one. The line first passes through a two-flop synchroniser. Each bit is then sampled once, at its midpoint, with the midpoint counted from the detected start edge.

The receiver has a two-step start. A low line first raises a start-candidate flag. If the line is still low at the mid-start sample, the frame is confirmed and the reception-active flag rises. If the line goes high again before that sample, the frame is dropped as a glitch. A confirmed frame always ends with data-ready, overrun or frame error raised.

A following start bit may arrive up to a quarter bit early without harm. Anything earlier is a frame error. One acknowledge input clears data-ready and both sticky error flags. A flag that is being set wins over an acknowledge that arrives at the same time.

Top module: `sc_byte_rx`

In the requirements, B = bit_clks + 1, H = floor(B/2), Q = floor(B/4), F = (11 + two_stop) × B. B must be at least 8. Times are counted in clocks.

## Requirements
- R1: While rst_n is low at a rising edge, the block returns to idle. All flags go to 0 and data_o goes to 0.
- R2: A frame with correct parity sets ready_o and presents the byte on data_o, with the first data bit on the line in bit 0. Neither error flag is set.
- R3: start_cand_o rises on the third rising edge after the line falls. If the line stays low for at most H+1 clocks, the attempt is dropped: start_cand_o falls, rx_active_o never rises, and no flag is set.
- R4: rx_active_o rises H+1 clocks after start_cand_o rises, on the same edge that start_cand_o falls. The two are never high together.
- R5: ready_o rises 9×B + H + 1 clocks after start_cand_o rises.
- R6: rx_active_o falls F − Q − 1 clocks after start_cand_o rises. Both stop settings apply: two_stop = 0 selects one stop bit and two_stop = 1 selects two.
- R7: The expected parity bit is the XOR of the eight data bits, XOR PAR_POL, XOR 1 (PAR_POL defaults to 0). On a mismatch, frame_err_o is set, ready_o is not set and data_o is left unchanged.
- R8: If the line falls from the stop-bit sample onward but fewer than F − Q clocks after the falling edge that began the frame, frame_err_o is set. The receiver then ignores the line until it is high again. A falling edge exactly F − Q clocks after the frame's falling edge starts a normal next frame.
- R9: If a byte completes while ready_o is high and ack is low, overrun_o is set, ready_o stays high and data_o keeps the earlier byte.
- R10: An ack high for one clock clears ready_o, overrun_o and frame_err_o on that edge. If a flag is set on the same edge as ack, the set wins, so an ack held high cannot hide a new byte or a new frame error.
- R11: While ready_o is high and not acknowledged, data_o does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_line | input | 1 | Asynchronous serial line, idle high |
| bit_clks | input | CPB_W | Clocks per bit minus one |
| two_stop | input | 1 | 0: one stop bit, 1: two stop bits |
| ack | input | 1 | Clears ready and error flags |
| data_o | output | 8 | Last accepted byte |
| start_cand_o | output | 1 | Start edge seen, not yet confirmed |
| rx_active_o | output | 1 | Frame confirmed and in progress |
| ready_o | output | 1 | New byte waiting |
| overrun_o | output | 1 | Sticky: a byte completed while the previous one was unread |
| frame_err_o | output | 1 | Sticky: parity mismatch or early start |

## Verification
Two functions can fall on the same edge: the acknowledge clearing the flags, and a frame completion setting them. The bench provokes this by holding ack high through a good frame and then through a frame with bad parity. It judges that ready_o, and then frame_err_o, are each seen high for a cycle, and that data_o carries the new byte only in the good case. A second collision is a completion while the earlier byte is still unread. That case must raise the overrun flag and keep the old byte, and the bench checks both at the end of the frame.

// File: rtl/scrx_pkg.sv
// Shared types for the smart-card character receiver.
package scrx_pkg;
    // Receiver sequencing states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for a low line
        ST_CAND = 2'd1,   // start edge seen, awaiting mid-start sample
        ST_RUN  = 2'd2,   // frame confirmed, sampling bits
        ST_WAIT = 2'd3    // after an early start, waiting for line high
    } rx_state_e;
endpackage

// File: rtl/scrx_sync.sv
// Multi-flop synchroniser for the asynchronous line input.
// Assumes the line idles high, so the flops reset to 1.
module scrx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] ff;

    // Shift the line through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) ff <= '1;
        else        ff <= {ff[STAGES-2:0], d_i};
    end

    assign q_o = ff[STAGES-1];
endmodule

// File: rtl/scrx_timing.sv
// Derives the frame timing points from the run-time bit period.
// Purely combinational; assumes bit_clks is held steady during a frame.
module scrx_timing #(
    parameter int CPB_W  = 13,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 17
) (
    input  logic [CPB_W-1:0] bit_clks,
    input  logic             two_stop,
    output logic [CNT_W-1:0] bit_len,
    output logic [CNT_W-1:0] half,
    output logic [CNT_W-1:0] end_pt
);
    localparam int BASE_BITS = DATA_W + 3;   // start + data + parity + one stop

    logic [CNT_W-1:0] frame_len;
    logic [CNT_W-1:0] quarter;

    // Bit length, mid-bit offset and the last clock of a frame.
    always_comb begin
        bit_len   = CNT_W'(bit_clks) + CNT_W'(1);
        half      = bit_len >> 1;
        quarter   = bit_len >> 2;
        frame_len = bit_len * CNT_W'(two_stop ? BASE_BITS + 1 : BASE_BITS);
        end_pt    = frame_len - quarter - CNT_W'(2);
    end
endmodule

// File: rtl/scrx_flags.sv
// Holds the output byte and the ready, overrun and frame-error flags.
// A set on the same edge as an acknowledge wins. The byte is kept on overrun.
module scrx_flags #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack,
    input  logic              set_byte,
    input  logic              set_ferr,
    input  logic [DATA_W-1:0] byte_i,
    output logic              rdy_q,
    output logic              ovr_q,
    output logic              ferr_q,
    output logic [DATA_W-1:0] data_q
);
    logic overrun_now;

    // A completion while an unread byte is waiting is an overrun.
    always_comb overrun_now = set_byte && rdy_q && !ack;

    // Flag and data register update; set beats ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_q  <= 1'b0;
            ovr_q  <= 1'b0;
            ferr_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (set_byte)      rdy_q <= 1'b1;
            else if (ack)      rdy_q <= 1'b0;
            if (overrun_now)   ovr_q <= 1'b1;
            else if (ack)      ovr_q <= 1'b0;
            if (set_ferr)      ferr_q <= 1'b1;
            else if (ack)      ferr_q <= 1'b0;
            if (set_byte && !overrun_now) data_q <= byte_i;
        end
    end

    // R11: an unread byte stays put.
    p_data_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_q && !ack) |=> $stable(data_q));
    // R9: an overrun leaves ready high and raises the overrun flag.
    p_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_byte && rdy_q && !ack) |=> (ovr_q && rdy_q));
    // R10: an acknowledge with nothing new clears every flag.
    p_ack_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !set_byte && !set_ferr) |=> (!rdy_q && !ovr_q && !ferr_q));
    // R10: a frame error is not hidden by a simultaneous acknowledge.
    p_set_beats_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && set_ferr) |=> ferr_q);
endmodule

// File: rtl/sc_byte_rx.sv
// Smart-card character receiver: start, data bits LSB first, parity, 1 or 2 stops.
// Bits are sampled at their midpoint counted from the detected start edge.
// Assumes the bit period is at least 8 clocks and does not change mid-frame.
module sc_byte_rx
    import scrx_pkg::*;
#(
    parameter int   CPB_W       = 13,
    parameter logic PAR_POL     = 1'b0,
    parameter int   SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_line,
    input  logic [CPB_W-1:0] bit_clks,
    input  logic             two_stop,
    input  logic             ack,
    output logic [7:0]       data_o,
    output logic             start_cand_o,
    output logic             rx_active_o,
    output logic             ready_o,
    output logic             overrun_o,
    output logic             frame_err_o
);
    localparam int DATA_W = 8;
    localparam int CNT_W  = CPB_W + $clog2(DATA_W + 5);
    localparam int IDX_W  = $clog2(DATA_W + 3);
    localparam logic [IDX_W-1:0] PAR_IDX  = IDX_W'(DATA_W + 1);
    localparam logic [IDX_W-1:0] STOP_IDX = IDX_W'(DATA_W + 2);

    rx_state_e         state;
    logic [CNT_W-1:0]  fcnt, nsamp;
    logic [CNT_W-1:0]  bit_len, half, end_pt;
    logic [IDX_W-1:0]  bidx;
    logic [DATA_W-1:0] shreg;
    logic rxd, at_samp, par_pt, par_ok, in_stop, set_byte, set_ferr;

    scrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(rx_line), .q_o(rxd)
    );

    scrx_timing #(.CPB_W(CPB_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_timing (
        .bit_clks(bit_clks), .two_stop(two_stop),
        .bit_len(bit_len), .half(half), .end_pt(end_pt)
    );

    // Sample decode: parity check and stop-window line watch.
    always_comb begin
        at_samp  = (fcnt == nsamp);
        par_pt   = (state == ST_RUN) && (bidx == PAR_IDX) && at_samp;
        par_ok   = (rxd == (^shreg ^ PAR_POL ^ 1'b1));
        in_stop  = (state == ST_RUN) && (bidx == STOP_IDX) && (fcnt >= nsamp);
        set_byte = par_pt && par_ok;
        set_ferr = (par_pt && !par_ok) || (in_stop && !rxd);
    end

    // Frame sequencer: start confirmation, bit sampling, stop window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            fcnt  <= '0;
            nsamp <= '0;
            bidx  <= '0;
            shreg <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    fcnt <= '0;
                    if (!rxd) state <= ST_CAND;
                end
                ST_CAND: begin
                    fcnt <= fcnt + CNT_W'(1);
                    if (rxd) begin
                        state <= ST_IDLE;
                    end else if (fcnt == half) begin
                        state <= ST_RUN;
                        nsamp <= half + bit_len;
                        bidx  <= IDX_W'(1);
                    end
                end
                ST_RUN: begin
                    fcnt <= fcnt + CNT_W'(1);
                    if (bidx <= PAR_IDX && at_samp) begin
                        if (bidx != PAR_IDX) shreg <= {rxd, shreg[DATA_W-1:1]};
                        bidx  <= bidx + IDX_W'(1);
                        nsamp <= nsamp + bit_len;
                    end else if (in_stop) begin
                        if (!rxd)               state <= ST_WAIT;
                        else if (fcnt >= end_pt) state <= ST_IDLE;
                    end
                end
                default: begin
                    if (rxd) state <= ST_IDLE;
                end
            endcase
        end
    end

    scrx_flags #(.DATA_W(DATA_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .ack(ack),
        .set_byte(set_byte), .set_ferr(set_ferr), .byte_i(shreg),
        .rdy_q(ready_o), .ovr_q(overrun_o), .ferr_q(frame_err_o), .data_q(data_o)
    );

    assign start_cand_o = (state == ST_CAND);
    assign rx_active_o  = (state == ST_RUN);

    // R3: a high line during the candidate phase drops the attempt.
    p_glitch_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAND && rxd) |=> (state == ST_IDLE));
    // R4: a confirmed frame is always entered from the candidate phase.
    p_run_from_cand_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_active_o) |-> $past(start_cand_o));
    // R5: a new byte only appears out of a running frame.
    p_ready_in_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(state == ST_RUN));
endmodule

// File: tb/tb_sc_byte_rx.sv
module tb_sc_byte_rx;
    localparam int B  = 16;
    localparam int H  = B / 2;
    localparam int Q  = B / 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line = 1'b1;
    logic [12:0] bit_clks = 13'(B - 1);
    logic two_stop = 1'b0;
    logic ack_drv = 1'b0;
    logic ack_auto = 1'b0;
    logic ack;
    logic [7:0] data_o;
    logic cand, run, rdy, ovr, ferr;

    assign ack = ack_drv | ack_auto;

    sc_byte_rx dut (
        .clk(clk), .rst_n(rst_n), .rx_line(line), .bit_clks(bit_clks),
        .two_stop(two_stop), .ack(ack), .data_o(data_o),
        .start_cand_o(cand), .rx_active_o(run), .ready_o(rdy),
        .overrun_o(ovr), .frame_err_o(ferr)
    );

    always #5 clk = ~clk;

    int total = 0;
    int fails = 0;
    int cyc = 0;
    int run_rises = 0;
    bit auto_en = 1'b0;
    bit finished = 1'b0;
    logic [12:0] expq[$];   // {chk_fall, ferr, ovr, rdy, data}

    always @(posedge clk) cyc++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: timing of each frame and pop/compare at its end.
    logic cand_p = 0, run_p = 0, rdy_p = 0;
    logic s_rdy = 0, s_ovr = 0, s_ferr = 0;
    int t_c = 0;
    int ack_cnt = 0;
    always @(negedge clk) begin
        ack_auto = 1'b0;
        if (ack_cnt == 1) ack_auto = 1'b1;
        if (ack_cnt > 0) ack_cnt--;
        if (rst_n) begin
            if (cand && !cand_p) begin
                t_c = cyc; s_rdy = 0; s_ovr = 0; s_ferr = 0;
            end
            s_rdy = s_rdy | rdy;
            s_ovr = s_ovr | ovr;
            s_ferr = s_ferr | ferr;
            if (run && !run_p) begin
                run_rises++;
                check("R4 run rise delay", cyc - t_c, H + 1);
                check("R4 cand low with run", {31'd0, cand}, 0);
            end
            if (rdy && !rdy_p) begin
                if (run) check("R5 ready rise delay", cyc - t_c, 9 * B + H + 1);
                if (auto_en) ack_cnt = 30;
            end
            if (!run && run_p) begin
                if (expq.size() == 0) begin
                    check("R2 unexpected frame end", 1, 0);
                end else begin
                    logic [12:0] e;
                    e = expq.pop_front();
                    check("R2 R11 data", data_o, e[7:0]);
                    check("R2 R10 ready", s_rdy, e[8]);
                    check("R9 overrun", s_ovr, e[9]);
                    check("R7 R8 frame error", s_ferr, e[10]);
                    if (e[12])
                        check("R6 run fall delay", cyc - t_c, (11 + two_stop) * B - Q - 1);
                end
            end
        end
        cand_p = cand; run_p = run; rdy_p = rdy;
    end

    task automatic bits(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: queue the expected result, then drive one frame.
    task automatic send(input logic [7:0] d, input bit badpar, input int stop_cyc,
                        input bit e_rdy, input bit e_ovr, input bit e_ferr,
                        input logic [7:0] e_data, input bit chk_fall);
        logic par;
        expq.push_back({chk_fall, 1'b0, e_ferr, e_ovr, e_rdy, e_data});
        par = ^d ^ 1'b0 ^ 1'b1 ^ badpar;
        line = 1'b0; bits(B);
        for (int i = 0; i < 8; i++) begin line = d[i]; bits(B); end
        line = par; bits(B);
        line = 1'b1; bits(stop_cyc);
    endtask

    task automatic pulse_ack;
        ack_drv = 1'b1; bits(1); ack_drv = 1'b0; bits(1);
    endtask

    initial begin
        bits(5);
        // R1: reset state
        check("R1 data", data_o, 0);
        check("R1 flags", {cand, run, rdy, ovr, ferr}, 0);
        rst_n = 1'b1;
        bits(10);

        // R2 basic frame, then ack (R10)
        send(8'hA5, 0, B + 20, 1, 0, 0, 8'hA5, 1);
        pulse_ack();
        check("R10 ready cleared", rdy, 0);

        // R9 overrun keeps old byte
        send(8'h3C, 0, B + 10, 1, 0, 0, 8'h3C, 1);
        send(8'hC3, 0, B + 10, 1, 1, 0, 8'h3C, 1);
        check("R11 old byte kept", data_o, 8'h3C);
        pulse_ack();
        check("R10 overrun cleared", {rdy, ovr}, 0);

        // R7 parity error
        send(8'h55, 1, B + 10, 0, 0, 1, 8'h3C, 1);
        check("R7 frame error sticky", ferr, 1);
        pulse_ack();
        check("R10 frame error cleared", ferr, 0);

        // R3 glitch of 5 clocks, with start-candidate timing
        begin
            int rr;
            rr = run_rises;
            line = 1'b0; bits(2);
            check("R3 cand not yet", cand, 0);
            bits(1);
            check("R3 cand on third edge", cand, 1);
            bits(2); line = 1'b1; bits(40);
            check("R3 short glitch no run", run_rises - rr, 0);
            // boundary: H+1 clocks low is still a glitch
            line = 1'b0; bits(H + 1); line = 1'b1; bits(40);
            check("R3 boundary glitch no run", run_rises - rr, 0);
            check("R3 no flags", {rdy, ovr, ferr}, 0);
        end

        // Back-to-back frames with late auto acknowledge; R8 boundary accepted
        auto_en = 1'b1;
        send(8'h01, 0, B, 1, 0, 0, 8'h01, 1);
        send(8'h80, 0, B, 1, 0, 0, 8'h80, 1);
        send(8'h33, 0, 11 * B - Q - 10 * B, 1, 0, 0, 8'h33, 1);
        send(8'h44, 0, B + 20, 1, 0, 0, 8'h44, 1);
        bits(40);
        check("R8 on-time start no error", {ovr, ferr}, 0);

        // R8 early start: one clock before the tolerance point
        send(8'h11, 0, 11 * B - Q - 1 - 10 * B, 1, 0, 1, 8'h11, 0);
        line = 1'b0; bits(B); line = 1'b1; bits(200);
        check("R8 back to idle", {cand, run}, 0);

        // R6 two stop bits
        two_stop = 1'b1;
        send(8'h5A, 0, 2 * B + 10, 1, 0, 0, 8'h5A, 1);
        bits(60);
        two_stop = 1'b0;
        auto_en = 1'b0;
        bits(20);

        // R10 acknowledge held high cannot hide a new flag
        ack_drv = 1'b1;
        send(8'h77, 0, B + 10, 1, 0, 0, 8'h77, 1);
        send(8'h0F, 1, B + 10, 0, 0, 1, 8'h77, 1);
        ack_drv = 1'b0;
        bits(2);
        check("R10 flags clear after held ack", {rdy, ovr, ferr}, 0);
        check("R2 held-ack byte", data_o, 8'h77);

        bits(10);
        check("R2 all frames seen", expq.size(), 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog R1: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule